// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block sits in the select stage that comes just ahead of instruction fetch in a simultaneous multithreaded core. Each of the T hardware threads has its own program counter. Every cycle the selector looks at which threads are active and not stalled, and picks up to M of them. For each chosen thread it drives a one-hot select vector and a thread id toward the instruction address path. The N-instruction fetch bandwidth is split evenly, so every chosen thread owns N/M consecutive fetch lanes.

A run-time policy input chooses how threads are ranked. Round-robin takes eligible threads in rotation order, starting from a pointer. The count policy takes the eligible threads with the fewest instructions in flight, and breaks ties by rotation order. The selection is combinational on the current inputs. The rotation pointer is the only state. It moves only when the fetch stage accepts a selection that contains at least one valid slot.

Top module: `fetch_thread_sel`

## Requirements
- R1: After reset the rotation pointer is at thread 0. With round-robin, all four threads eligible and no accepted fetch, slot 0 selects thread 0 and slot 1 selects thread 1.
- R2: A thread whose active bit is 0, or whose stall bit is 1, never appears in any select slot.
- R3: No thread is selected in two slots. Each valid slot's one-hot vector has exactly the bit of its thread id set. Invalid slots drive an all-zero one-hot vector and thread id 0.
- R4: When fewer than M threads are eligible, the valid slots are the lowest-numbered slots and the remaining slots are invalid. When at least M are eligible, every slot is valid.
- R5: With round-robin (policy input 0), slot k holds the k-th eligible thread in rotation order, beginning at the pointer and wrapping from thread T-1 to thread 0.
- R6: With the count policy (policy input 1), slots are filled in ascending order of in-flight count. The count for thread i is taken from bits [CW*i +: CW] of the count input.
- R7: Under the count policy, equal counts are ordered by rotation position from the pointer, so the earlier thread in rotation takes the lower slot.
- R8: On a clock edge where fetch accept is 1 and at least one slot is valid, the pointer moves to the thread that follows the furthest-in-rotation selected thread. On every other edge the pointer keeps its value.
- R9: Fetch lane l, for l in 0..N-1, carries the thread id and valid bit of slot l/(N/M). Each selected thread therefore receives N/M lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 1 | 0 = round-robin, 1 = fewest in flight |
| thread_active_i | input | T | Thread has a valid program counter |
| thread_stall_i | input | T | Thread is stalled this cycle |
| inflight_cnt_i | input | T*CW | Per-thread in-flight instruction counts |
| fetch_accept_i | input | 1 | Fetch stage takes the current selection |
| sel_valid_o | output | M | Slot holds a selected thread |
| sel_onehot_o | output | M*T | Per-slot one-hot thread select |
| sel_tid_o | output | M*log2(T) | Per-slot thread id |
| lane_valid_o | output | N | Fetch lane is in use |
| lane_tid_o | output | N*log2(T) | Thread owning each fetch lane |

## Verification
The bench targets pointer movement after a count-policy pick whose slot order is not its rotation order. A design that advanced past slot M-1 instead of past the furthest-rotated thread would restart one thread too early. Count ties with a non-zero pointer are exercised, which catches a tie-break on raw thread index. The bench also runs sparse eligibility, where a design that leaves gaps or stale ids in unused slots would drive invalid fetch lanes. Accepts with nothing valid and cycles without an accept are checked as well, so a pointer that moves freely shows up in the next round-robin pick.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  typedef enum logic {
    POL_RR  = 1'b0,
    POL_CNT = 1'b1
  } tsel_policy_e;
endpackage

// File: rtl/tsel_keygen.sv
module tsel_keygen #(
  parameter int T  = 4,
  parameter int CW = 4,
  parameter int TW = $clog2(T),
  localparam int KW = CW + TW
) (
  input  logic [TW-1:0]         ptr_i,
  input  logic                  policy_i,
  input  logic [T-1:0]          active_i,
  input  logic [T-1:0]          stall_i,
  input  logic [T-1:0][CW-1:0]  cnt_i,
  output logic [T-1:0]          elig_o,
  output logic [T-1:0][TW-1:0]  pos_o,
  output logic [T-1:0][KW-1:0]  key_o
);
  import tsel_pkg::*;

  for (genvar i = 0; i < T; i++) begin : g_thr
    int p;
    always_comb begin
      p = (i >= int'(ptr_i)) ? i - int'(ptr_i) : i + T - int'(ptr_i);
      pos_o[i]  = TW'(p);
      elig_o[i] = active_i[i] & ~stall_i[i];
      // rotation position in low bits breaks count ties
      key_o[i]  = {(tsel_policy_e'(policy_i) == POL_CNT) ? cnt_i[i] : CW'(0), pos_o[i]};
    end
  end
endmodule

// File: rtl/tsel_pick.sv
module tsel_pick #(
  parameter int T  = 4,
  parameter int KW = 6
) (
  input  logic [T-1:0]         cand_i,
  input  logic [T-1:0][KW-1:0] key_i,
  output logic [T-1:0]         grant_o,
  output logic                 found_o
);
  logic [KW-1:0] best;

  always_comb begin
    grant_o = '0;
    found_o = 1'b0;
    best    = '1;
    for (int i = 0; i < T; i++) begin
      if (cand_i[i] && (!found_o || key_i[i] < best)) begin
        best       = key_i[i];
        grant_o    = '0;
        grant_o[i] = 1'b1;
        found_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int T  = 4,
  parameter int M  = 2,
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int TW  = $clog2(T),
  localparam int KW  = CW + TW,
  localparam int LPS = N / M
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 policy_i,
  input  logic [T-1:0]         thread_active_i,
  input  logic [T-1:0]         thread_stall_i,
  input  logic [T-1:0][CW-1:0] inflight_cnt_i,
  input  logic                 fetch_accept_i,
  output logic [M-1:0]         sel_valid_o,
  output logic [M-1:0][T-1:0]  sel_onehot_o,
  output logic [M-1:0][TW-1:0] sel_tid_o,
  output logic [N-1:0]         lane_valid_o,
  output logic [N-1:0][TW-1:0] lane_tid_o
);
  logic [TW-1:0]        ptr_q;
  logic [T-1:0]         elig;
  logic [T-1:0][TW-1:0] pos;
  logic [T-1:0][KW-1:0] key;
  logic [M:0][T-1:0]    cand;
  logic [T-1:0]         sel_any;
  logic [TW-1:0]        far_pos;

  tsel_keygen #(.T(T), .CW(CW), .TW(TW)) i_keygen (
    .ptr_i   (ptr_q),
    .policy_i(policy_i),
    .active_i(thread_active_i),
    .stall_i (thread_stall_i),
    .cnt_i   (inflight_cnt_i),
    .elig_o  (elig),
    .pos_o   (pos),
    .key_o   (key)
  );

  assign cand[0] = elig;

  for (genvar m = 0; m < M; m++) begin : g_slot
    tsel_pick #(.T(T), .KW(KW)) i_pick (
      .cand_i (cand[m]),
      .key_i  (key),
      .grant_o(sel_onehot_o[m]),
      .found_o(sel_valid_o[m])
    );
    assign cand[m+1] = cand[m] & ~sel_onehot_o[m];

    always_comb begin
      sel_tid_o[m] = '0;
      for (int i = 0; i < T; i++)
        if (sel_onehot_o[m][i]) sel_tid_o[m] = TW'(i);
    end

    a_r2_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o[m] |-> (thread_active_i[sel_tid_o[m]] && !thread_stall_i[sel_tid_o[m]]));

    if (m > 0) begin : g_ord
      a_r4_packed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o[m] |-> sel_valid_o[m-1]);
      a_r6_count_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (policy_i && sel_valid_o[m]) |->
          (inflight_cnt_i[sel_tid_o[m-1]] <= inflight_cnt_i[sel_tid_o[m]]));
    end
  end

  for (genvar l = 0; l < N; l++) begin : g_lane
    assign lane_valid_o[l] = sel_valid_o[l / LPS];
    assign lane_tid_o[l]   = sel_tid_o[l / LPS];
  end

  // pointer moves past the selected thread furthest along in rotation
  always_comb begin
    sel_any = '0;
    for (int m = 0; m < M; m++) sel_any |= sel_onehot_o[m];
    far_pos = '0;
    for (int i = 0; i < T; i++)
      if (sel_any[i] && pos[i] > far_pos) far_pos = pos[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (fetch_accept_i && |sel_valid_o)
      ptr_q <= TW'((int'(ptr_q) + int'(far_pos) + 1) % T);
  end

  a_r3_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_any) == $countones(sel_valid_o));
  a_r4_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(thread_active_i & ~thread_stall_i) >= M) |-> (&sel_valid_o));
  a_r8_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_accept_i && |sel_valid_o) |=> $stable(ptr_q));
endmodule

// File: tb/test_fetch_thread_sel.sv
module test_fetch_thread_sel;
  localparam int CLK_PERIOD = 10;
  localparam int T = 4, M = 2, N = 8, CW = 4, TW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic policy_i = 1'b0, fetch_accept_i = 1'b0;
  logic [T-1:0] thread_active_i = '1, thread_stall_i = '0;
  logic [T-1:0][CW-1:0] inflight_cnt_i = '0;
  logic [M-1:0] sel_valid_o;
  logic [M-1:0][T-1:0] sel_onehot_o;
  logic [M-1:0][TW-1:0] sel_tid_o;
  logic [N-1:0] lane_valid_o;
  logic [N-1:0][TW-1:0] lane_tid_o;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fetch_thread_sel #(.T(T), .M(M), .N(N), .CW(CW)) i_fetch_thread_sel (.*);

  typedef struct packed {
    logic pol; logic [3:0] act; logic [3:0] stl; logic [15:0] cnt;
    logic [1:0] ev; logic [1:0] t0; logic [1:0] t1;
  } vec_t;

  // pointer stays at 0 throughout the table (no accepts)
  localparam vec_t VECS [8] = '{
    '{1'b0, 4'b1111, 4'b0000, 16'h0000, 2'b11, 2'd0, 2'd1},  // R5
    '{1'b0, 4'b1111, 4'b0011, 16'h0000, 2'b11, 2'd2, 2'd3},  // R2
    '{1'b0, 4'b0100, 4'b0000, 16'h0000, 2'b01, 2'd2, 2'd0},  // R4 R9
    '{1'b0, 4'b0000, 4'b0000, 16'h0000, 2'b00, 2'd0, 2'd0},  // R4
    '{1'b1, 4'b1111, 4'b0000, 16'h7135, 2'b11, 2'd2, 2'd1},  // R6
    '{1'b1, 4'b1111, 4'b0000, 16'h2222, 2'b11, 2'd0, 2'd1},  // R7
    '{1'b1, 4'b1111, 4'b0000, 16'h4949, 2'b11, 2'd1, 2'd3},  // R7
    '{1'b1, 4'b1111, 4'b0100, 16'h1066, 2'b11, 2'd3, 2'd0}   // R2 R6
  };

  task automatic check(string req, logic [1:0] ev, logic [1:0] t0, logic [1:0] t1);
    logic [M-1:0][T-1:0] eoh;
    logic [M-1:0][TW-1:0] etid;
    logic [N-1:0] elv;
    logic [N-1:0][TW-1:0] elt;
    etid[0] = ev[0] ? t0 : 2'd0;
    etid[1] = ev[1] ? t1 : 2'd0;
    eoh[0] = ev[0] ? (4'b1 << t0) : 4'b0;
    eoh[1] = ev[1] ? (4'b1 << t1) : 4'b0;
    for (int l = 0; l < N; l++) begin
      elv[l] = ev[l/4];
      elt[l] = etid[l/4];
    end
    n_chk++;
    if (sel_valid_o !== ev || sel_tid_o !== etid || sel_onehot_o !== eoh ||
        lane_valid_o !== elv || lane_tid_o !== elt) begin
      n_fail++;
      $display("FAIL %s: valid=%b tid=%h oh=%h lanes=%b/%h exp valid=%b tid=%h oh=%h lanes=%b/%h",
               req, sel_valid_o, sel_tid_o, sel_onehot_o, lane_valid_o, lane_tid_o,
               ev, etid, eoh, elv, elt);
    end
  endtask

  task automatic drive(logic pol, logic [3:0] act, logic [3:0] stl, logic [15:0] cnt);
    @(negedge clk_i);
    policy_i = pol; thread_active_i = act; thread_stall_i = stl; inflight_cnt_i = cnt;
    #1;
  endtask

  task automatic accept_edge();
    fetch_accept_i = 1'b1;
    @(posedge clk_i);
    #1 fetch_accept_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2 check("R1 in reset", 2'b11, 2'd0, 2'd1);
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    foreach (VECS[k]) begin
      drive(VECS[k].pol, VECS[k].act, VECS[k].stl, VECS[k].cnt);
      check($sformatf("vec%0d", k), VECS[k].ev, VECS[k].t0, VECS[k].t1);
    end

    // R8: accept round-robin 0,1 -> pointer 2
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    accept_edge();
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R8 advance", 2'b11, 2'd2, 2'd3);
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R8 hold without accept", 2'b11, 2'd2, 2'd3);
    // R7: equal counts, pointer 2
    drive(1'b1, 4'b1111, 4'b0000, 16'h3333);
    check("R7 tie from pointer", 2'b11, 2'd2, 2'd3);
    // R8: accept with nothing valid
    drive(1'b0, 4'b0000, 4'b0000, 16'h0000);
    accept_edge();
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R8 empty accept", 2'b11, 2'd2, 2'd3);
    // R5 wrap: accept 2,3 -> pointer 0
    accept_edge();
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R5 wrap", 2'b11, 2'd0, 2'd1);
    // R6 slot order 1,0; R8 pointer goes past thread 1 -> 2
    drive(1'b1, 4'b1111, 4'b0000, 16'h9915);
    check("R6 count order", 2'b11, 2'd1, 2'd0);
    accept_edge();
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R8 furthest in rotation", 2'b11, 2'd2, 2'd3);
    // R5 with pointer 2 and thread 3 stalled
    drive(1'b0, 4'b1111, 4'b1000, 16'h0000);
    check("R5 rotation skip", 2'b11, 2'd2, 2'd0);
    // R1: reset returns pointer to 0
    @(negedge clk_i) rst_ni = 1'b0;
    drive(1'b0, 4'b1111, 4'b0000, 16'h0000);
    check("R1 reset pointer", 2'b11, 2'd0, 2'd1);
    @(negedge clk_i) rst_ni = 1'b1;
    drive(1'b0, 4'b1000, 4'b0000, 16'h0000);
    check("R9 single thread lanes", 2'b01, 2'd3, 2'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule